// File: doc/BRIEF.md
# Multi-Port PHY Link Status Poller

This block watches the link state of several Ethernet ports on its own, with no software involvement. It walks the ports in a fixed rotation. For each port it asks an external management-bus master to read the status register of that port's PHY, at a PHY address taken from a per-port configuration field. Bit 2 of the returned word is the link indication. A port whose link reads down is placed in a link-fail condition, and its port reset output stays asserted until a later poll of that port reads the link as up.

Each port also has a force-link input. While it is set, the port reports link up and is released from reset. The poller also skips that port, so it uses no management-bus time. Clearing the force input sends the port back into link-fail until a poll confirms the link. After a global reset every port starts in link-fail.

The management side is a level request with a one-cycle completion pulse. The block holds the request, the PHY address and the register address steady until it sees `mgmt_done`, and it never has more than one read outstanding. The serial shifter that runs the management wires sits outside this block.

Top module: `phy_link_poller`

The sequencer has two states:
- `ST_PICK` chooses the next non-forced port after the last one served. It moves to `ST_ISSUE` when such a port exists. It stays in `ST_PICK` when every port is forced.
- `ST_ISSUE` drives the read request. It returns to `ST_PICK` on `mgmt_done` and records that port as the last one served.

## Requirements
- R1: Only one read is outstanding at a time. `mgmt_req` stays high, with a stable PHY address, until a cycle with `mgmt_done` high. `mgmt_reg_addr` is always 1 while `mgmt_req` is high.
- R2: During a read, `mgmt_phy_addr` equals the served port's field of `cfg_phy_addr`. Port p occupies bits [5p+4:5p].
- R3: Non-forced ports are served in the rotation 0, 1, 2, 0, … and the first read after reset goes to port 0.
- R4: If bit 2 of `mgmt_rdata` is 1 in the done cycle, that port's `link_up` becomes 1 and its `port_reset` becomes 0 two clock edges after the done cycle.
- R5: If bit 2 is 0 in the done cycle, the port enters link-fail: `link_up` = 0 and `port_reset` = 1, whatever the other data bits are.
- R6: A port in link-fail stays in reset while other ports are polled. It leaves link-fail only when its own poll reads bit 2 as 1.
- R7: During reset, and after reset until a port's first successful poll, every non-forced port has `port_reset` = 1 and `link_up` = 0.
- R8: When a port's `cfg_force_link` bit is set, that port's `link_up` is 1 and its `port_reset` is 0 one clock edge later. The port is skipped by the rotation, and read data for it has no effect.
- R9: With every port forced, no new read is issued.
- R10: Clearing a port's force bit puts that port in link-fail (`port_reset` = 1, `link_up` = 0) one clock edge later, until a poll reads link up.
- R11: `port_reset` changes only as a result of a completed poll of that port, or a change of that port's force bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_phy_addr | input | NUM_PORTS*PHY_ADDR_W | Packed per-port PHY addresses; port p at bits [5p+4:5p] |
| cfg_force_link | input | NUM_PORTS | Per-port force-link-up bit |
| mgmt_req | output | 1 | Read request to the management master, held until done |
| mgmt_phy_addr | output | PHY_ADDR_W | PHY address of the current read |
| mgmt_reg_addr | output | REG_ADDR_W | Register address of the current read (always 1) |
| mgmt_rdata | input | DATA_W | Read data, valid in the done cycle |
| mgmt_done | input | 1 | One-cycle completion pulse of the current read |
| link_up | output | NUM_PORTS | Per-port registered link state |
| port_reset | output | NUM_PORTS | Per-port registered reset, high while in link-fail |

## Verification
The bench builds the block with its defaults: three ports, 5-bit PHY addresses, 16-bit read data and link bit 2. With three ports the rotation wraps within a few reads. Skipping one forced port then changes the visible order from 0,1,2 to 1,2,1, and forcing all three reaches the case where no port can be picked. The distinct 5-bit addresses 5, 17 and 30 make any port-select or address-slice error show up directly on `mgmt_phy_addr`.

// File: rtl/poller_pkg.sv
package poller_pkg;

    typedef enum logic {
        ST_PICK  = 1'b0,
        ST_ISSUE = 1'b1
    } poll_state_t;

endpackage

// File: rtl/rr_port_select.sv
module rr_port_select #(
    parameter int NUM_PORTS = 3,
    parameter int IDX_W     = 2
) (
    input  logic [IDX_W-1:0]     last_idx,
    input  logic [NUM_PORTS-1:0] skip_mask,
    output logic [IDX_W-1:0]     next_idx,
    output logic                 next_valid
);

    function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] base, input int step);
        int sum;
        sum = int'(base) + step;
        if (sum >= NUM_PORTS) sum = sum - NUM_PORTS;
        return IDX_W'(sum);
    endfunction

    // Walk offsets from farthest to nearest so the nearest eligible port wins.
    always_comb begin
        next_idx   = '0;
        next_valid = 1'b0;
        for (int k = NUM_PORTS; k >= 1; k--) begin
            if (!skip_mask[wrap_add(last_idx, k)]) begin
                next_idx   = wrap_add(last_idx, k);
                next_valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
    import poller_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int IDX_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pick_valid,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             mgmt_done,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] last_idx,
    output logic             mgmt_req,
    output logic             poll_done
);

    localparam logic [IDX_W-1:0] LAST_PORT = IDX_W'(NUM_PORTS - 1);

    poll_state_t      state_q, state_d;
    logic [IDX_W-1:0] cur_q, cur_d;
    logic [IDX_W-1:0] last_q, last_d;

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        last_d  = last_q;
        unique case (state_q)
            ST_PICK: begin
                if (pick_valid) begin
                    cur_d   = pick_idx;
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (mgmt_done) begin
                    last_d  = cur_q;
                    state_d = ST_PICK;
                end
            end
            default: state_d = ST_PICK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PICK;
            cur_q   <= '0;
            last_q  <= LAST_PORT;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            last_q  <= last_d;
        end
    end

    always_comb begin
        mgmt_req  = (state_q == ST_ISSUE);
        poll_done = (state_q == ST_ISSUE) && mgmt_done;
        cur_idx   = cur_q;
        last_idx  = last_q;
    end

endmodule

// File: rtl/link_state_bank.sv
module link_state_bank #(
    parameter int NUM_PORTS = 3,
    parameter int IDX_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] force_link,
    input  logic                 poll_done,
    input  logic [IDX_W-1:0]     poll_idx,
    input  logic                 poll_link,
    output logic [NUM_PORTS-1:0] link_up,
    output logic [NUM_PORTS-1:0] port_reset
);

    logic [NUM_PORTS-1:0] fail_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // Forcing re-arms the fail flag so that releasing the force needs a fresh good poll.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fail_q[p] <= 1'b1;
            end else if (force_link[p]) begin
                fail_q[p] <= 1'b1;
            end else if (poll_done && (poll_idx == IDX_W'(p))) begin
                fail_q[p] <= ~poll_link;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                port_reset[p] <= 1'b1;
                link_up[p]    <= 1'b0;
            end else begin
                port_reset[p] <= fail_q[p] & ~force_link[p];
                link_up[p]    <= force_link[p] | ~fail_q[p];
            end
        end
    end

endmodule

// File: rtl/phy_link_poller.sv
module phy_link_poller #(
    parameter int NUM_PORTS  = 3,
    parameter int PHY_ADDR_W = 5,
    parameter int REG_ADDR_W = 5,
    parameter int DATA_W     = 16,
    parameter int STATUS_REG = 1,
    parameter int LINK_BIT   = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PORTS*PHY_ADDR_W-1:0] cfg_phy_addr,
    input  logic [NUM_PORTS-1:0]            cfg_force_link,
    output logic                            mgmt_req,
    output logic [PHY_ADDR_W-1:0]           mgmt_phy_addr,
    output logic [REG_ADDR_W-1:0]           mgmt_reg_addr,
    input  logic [DATA_W-1:0]               mgmt_rdata,
    input  logic                            mgmt_done,
    output logic [NUM_PORTS-1:0]            link_up,
    output logic [NUM_PORTS-1:0]            port_reset
);

    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_valid;
    logic             poll_done;
    logic             unused_rdata;

    assign unused_rdata = ^mgmt_rdata;

    rr_port_select #(
        .NUM_PORTS (NUM_PORTS),
        .IDX_W     (IDX_W)
    ) i_select (
        .last_idx   (last_idx),
        .skip_mask  (cfg_force_link),
        .next_idx   (pick_idx),
        .next_valid (pick_valid)
    );

    poll_fsm #(
        .NUM_PORTS (NUM_PORTS),
        .IDX_W     (IDX_W)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx),
        .mgmt_done  (mgmt_done),
        .cur_idx    (cur_idx),
        .last_idx   (last_idx),
        .mgmt_req   (mgmt_req),
        .poll_done  (poll_done)
    );

    link_state_bank #(
        .NUM_PORTS (NUM_PORTS),
        .IDX_W     (IDX_W)
    ) i_links (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_link (cfg_force_link),
        .poll_done  (poll_done),
        .poll_idx   (cur_idx),
        .poll_link  (mgmt_rdata[LINK_BIT]),
        .link_up    (link_up),
        .port_reset (port_reset)
    );

    assign mgmt_phy_addr = cfg_phy_addr[cur_idx*PHY_ADDR_W +: PHY_ADDR_W];
    assign mgmt_reg_addr = REG_ADDR_W'(STATUS_REG);

endmodule

// File: rtl/poller_checker.sv
module poller_checker #(
    parameter int NUM_PORTS  = 3,
    parameter int PHY_ADDR_W = 5,
    parameter int IDX_W      = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PORTS-1:0]  cfg_force_link,
    input logic                  mgmt_req,
    input logic                  mgmt_done,
    input logic [PHY_ADDR_W-1:0] mgmt_phy_addr,
    input logic [IDX_W-1:0]      cur_idx,
    input logic                  poll_done,
    input logic [NUM_PORTS-1:0]  link_up,
    input logic [NUM_PORTS-1:0]  port_reset
);

    logic [1:0] settle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) settle <= '0;
        else if (settle != 2'd3) settle <= settle + 2'd1;
    end

    // R1: a read is held steady until it completes
    assert_hold_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_req && !mgmt_done) |=> (mgmt_req && $stable(cur_idx)));

    // R9: no port can be picked, so nothing new starts
    assert_idle_all_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (settle == 2'd3 && $past(&cfg_force_link) && !$past(mgmt_req)) |-> !mgmt_req);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        // R8: a forced port is up and out of reset one edge later
        assert_forced_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (settle == 2'd3 && $past(cfg_force_link[p])) |-> (link_up[p] && !port_reset[p]));

        // R11: reset output moves only after its own poll or a force edge
        assert_reset_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (settle == 2'd3 && !$stable(port_reset[p])) |->
                (($past(poll_done, 2) && $past(cur_idx, 2) == IDX_W'(p)) ||
                 ($past(cfg_force_link[p]) != $past(cfg_force_link[p], 2))));
    end

endmodule

bind phy_link_poller poller_checker #(
    .NUM_PORTS  (NUM_PORTS),
    .PHY_ADDR_W (PHY_ADDR_W),
    .IDX_W      (IDX_W)
) i_poller_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_force_link (cfg_force_link),
    .mgmt_req       (mgmt_req),
    .mgmt_done      (mgmt_done),
    .mgmt_phy_addr  (mgmt_phy_addr),
    .cur_idx        (cur_idx),
    .poll_done      (poll_done),
    .link_up        (link_up),
    .port_reset     (port_reset)
);

// File: tb/test_phy_link_poller.sv
`timescale 1ns/1ps
module test_phy_link_poller;

    localparam int NP = 3;
    localparam int AW = 5;
    localparam int DW = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NP*AW-1:0] cfg_phy_addr;
    logic [NP-1:0]    cfg_force_link;
    logic             mgmt_req;
    logic [AW-1:0]    mgmt_phy_addr;
    logic [4:0]       mgmt_reg_addr;
    logic [DW-1:0]    mgmt_rdata;
    logic             mgmt_done;
    logic [NP-1:0]    link_up;
    logic [NP-1:0]    port_reset;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;
    logic [AW-1:0] port_addr [NP] = '{5'd5, 5'd17, 5'd30};

    always #2 clk = ~clk;

    phy_link_poller i_phy_link_poller (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_phy_addr   (cfg_phy_addr),
        .cfg_force_link (cfg_force_link),
        .mgmt_req       (mgmt_req),
        .mgmt_phy_addr  (mgmt_phy_addr),
        .mgmt_reg_addr  (mgmt_reg_addr),
        .mgmt_rdata     (mgmt_rdata),
        .mgmt_done      (mgmt_done),
        .link_up        (link_up),
        .port_reset     (port_reset)
    );

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_req();
        while (mgmt_req !== 1'b1) @(negedge clk);
    endtask

    // Answer the pending read, checking which port it targets.
    task automatic serve_raw(int exp_port, logic [DW-1:0] data);
        wait_req();
        check_eq($sformatf("R2 R3 read address for port %0d", exp_port),
                 32'(mgmt_phy_addr), 32'(port_addr[exp_port]));
        check_eq("R1 register address", 32'(mgmt_reg_addr), 32'd1);
        mgmt_rdata = data;
        mgmt_done  = 1'b1;
        @(negedge clk);
        mgmt_done  = 1'b0;
        mgmt_rdata = '0;
    endtask

    task automatic serve(int exp_port, logic [DW-1:0] data, bit exp_up);
        serve_raw(exp_port, data);
        @(negedge clk);
        check_eq($sformatf("R4 R5 link_up port %0d data %0h", exp_port, data),
                 32'(link_up[exp_port]), 32'(exp_up));
        check_eq($sformatf("R4 R5 port_reset port %0d", exp_port),
                 32'(port_reset[exp_port]), 32'(!exp_up));
    endtask

    task automatic t_reset_state();
        rst_n          = 1'b0;
        mgmt_done      = 1'b0;
        mgmt_rdata     = '0;
        cfg_force_link = '0;
        cfg_phy_addr   = {port_addr[2], port_addr[1], port_addr[0]};
        repeat (3) @(negedge clk);
        check_eq("R7 port_reset in reset", 32'(port_reset), 32'h7);
        check_eq("R7 link_up in reset", 32'(link_up), 32'h0);
        check_eq("R1 no request in reset", 32'(mgmt_req), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R7 ports stay in fail before first poll", 32'(port_reset), 32'h7);
    endtask

    task automatic t_hold_request();
        wait_req();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_eq("R1 request held without done", 32'(mgmt_req), 32'h1);
            check_eq("R1 address stable while pending", 32'(mgmt_phy_addr), 32'(port_addr[0]));
            check_eq("R11 reset unchanged while pending", 32'(port_reset), 32'h7);
        end
        serve(0, 16'h0004, 1'b1);
    endtask

    task automatic t_first_round();
        serve(1, 16'h0000, 1'b0);
        serve(2, 16'hFFFB, 1'b0);
        check_eq("R5 only bit 2 matters", 32'(link_up), 32'h1);
    endtask

    task automatic t_recover();
        serve(0, 16'h0000, 1'b0);
        serve(1, 16'hFFFF, 1'b1);
        serve(2, 16'h0004, 1'b1);
        check_eq("R6 port 0 stays in reset while others polled", 32'(port_reset[0]), 32'h1);
    endtask

    task automatic t_force();
        wait_req();
        cfg_force_link = 3'b001;
        @(negedge clk);
        check_eq("R8 forced port link_up", 32'(link_up[0]), 32'h1);
        check_eq("R8 forced port out of reset", 32'(port_reset[0]), 32'h0);
        serve_raw(0, 16'h0000);
        @(negedge clk);
        check_eq("R8 read data ignored for forced port", 32'(link_up[0]), 32'h1);
        serve(1, 16'h0004, 1'b1);
        serve(2, 16'h0004, 1'b1);
        serve(1, 16'h0004, 1'b1);
    endtask

    task automatic t_release();
        wait_req();
        cfg_force_link = 3'b000;
        @(negedge clk);
        check_eq("R10 released port back in reset", 32'(port_reset[0]), 32'h1);
        check_eq("R10 released port link down", 32'(link_up[0]), 32'h0);
        serve(2, 16'h0004, 1'b1);
        serve(0, 16'h0004, 1'b1);
    endtask

    task automatic t_all_forced();
        wait_req();
        cfg_force_link = 3'b111;
        @(negedge clk);
        check_eq("R8 all forced ports up", 32'(link_up), 32'h7);
        serve_raw(1, 16'h0000);
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (mgmt_req) seen++;
            end
            check_eq("R9 no read with all ports forced", 32'(seen), 32'h0);
        end
        check_eq("R9 ports stay up", 32'(link_up), 32'h7);
        check_eq("R9 no port in reset", 32'(port_reset), 32'h0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        t_reset_state();
        t_hold_request();
        t_first_round();
        t_recover();
        t_force();
        t_release();
        t_all_forced();
        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog R1: actual=hung expected=read completion");
            report();
            $finish;
        end
    end

endmodule